// File: doc/BRIEF.md
# Touch ADC Serial Command and Readout Interface

This block is the digital front end of a touch-screen converter. A host drives a chip-select (active low), a serial clock and a serial data line. The block waits for a high start bit, gathers a control byte that picks the measurement channel, the result resolution, the reference choice and the power mode, and presents those fields to the panel driver logic with a one-cycle strobe. It then marks an acquisition window, raises BUSY for one serial clock, and shifts a result word out MSB first on DOUT. The converter core is outside the block: a parallel sample word is taken in when BUSY rises and serialized as if it had just been converted.

All three serial inputs are brought into the system clock domain through synchronizers, and serial clock edges are found there. Transfers of 24 serial clocks per conversion are supported, as are overlapped transfers of 16 or 15 clocks, where the next control byte is clocked in while the tail of the current result is still going out. Driving DOUT and BUSY onto pins is left to a pad cell, controlled by the drive-enable output.

Top module: `tsc_serial_if`

## Requirements
- R1: While chip-select is low and no control byte is being taken in, a low DIN at a serial clock rising edge is ignored; the first high DIN seen is the start bit and counts as clock 1 of the control byte.
- R2: The seven bits after the start bit are, in order, channel bits 2, 1, 0, a resolution bit (1 = 8-bit result), a reference bit and power bits 1, 0; after the eighth rising edge `cfg_vld` pulses for exactly one system clock with these fields on `cfg_chan`, `cfg_mode8`, `cfg_ref_ext` and `cfg_pd`.
- R3: BUSY rises at the falling edge that ends clock 8 of a control byte and falls at the next falling edge, so it is high for exactly one serial clock.
- R4: With the resolution bit 0, the sample word is latched when BUSY rises and its bits 11 down to 0 appear on DOUT at the falling edges of clocks 9 to 20.
- R5: With the resolution bit 1, bits 11 down to 4 of the sample word appear on DOUT at the falling edges of clocks 9 to 16.
- R6: DOUT is 0 while BUSY is high, before the first result bit, and after the last result bit until a new result starts.
- R7: While chip-select is high, `drv_en`, DOUT, BUSY and the acquisition flag are low and any transfer is abandoned; after chip-select falls again a start bit is accepted on the first clock.
- R8: The acquisition flag `acq` rises at the rising edge that samples channel bit 0 and falls at the falling edge that ends clock 8.
- R9: After a 12-bit command, a new start bit is accepted from clock 16 on (counting the start bit as clock 1); a high DIN on clocks 9 to 15 is ignored, and the current result keeps shifting while the next control byte is clocked in.
- R10: After an 8-bit command, a new start bit is accepted from clock 17 on, the clock after the last result bit was presented; a high DIN on clock 16 is ignored.
- R11: DOUT and BUSY change only in response to a serial clock falling edge or chip-select rising, never at a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip-select from the host, active low |
| dclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data, sampled on the rising edge |
| sample | input | RES_HI (12) | Result word from the converter core |
| dout | output | 1 | Serial result data |
| busy | output | 1 | Conversion busy flag |
| drv_en | output | 1 | High when DOUT and BUSY should be driven onto pins |
| acq | output | 1 | Acquisition window for the analog side |
| cfg_vld | output | 1 | One-cycle strobe for the captured fields |
| cfg_chan | output | 3 | Channel select field |
| cfg_mode8 | output | 1 | Resolution field, 1 = 8-bit |
| cfg_ref_ext | output | 1 | Reference select field |
| cfg_pd | output | 2 | Power control field |

## Verification
The bench aims at the boundaries of the overlap window: a high DIN on clock 15 after a 12-bit command and on clock 16 after an 8-bit one must start nothing, while clock 16 and clock 17 respectively must start a new byte; a window off by one would either drop the fast 15-clock mode or launch a phantom command and a second strobe. Leading zeros before the start bit and a command following an aborted one check that hunting restarts cleanly on chip-select, where a design keeping its window counter would refuse the new start. Bit-by-bit readout in both resolutions, with overlapped bytes, exposes a wrong latch instant or a shift that runs past the last bit instead of filling with zeros, and mid-clock samples show whether outputs move on the wrong edge.

// File: rtl/tsc_pkg.sv
// Shared definitions for the touch ADC serial interface.
// Assumes a control byte of one start bit followed by seven field bits.
package tsc_pkg;
    localparam int CTRL_BITS = 8;
    localparam int CH_W      = 3;

    // Decoded command fields, packed in the order they arrive after the start bit
    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            mode8;
        logic            ref_ext;
        logic [1:0]      pd;
    } tsc_cmd_t;
endpackage

// File: rtl/tsc_sync.sv
// Multi-bit synchronizer chain for asynchronous serial inputs.
// Assumes STAGES >= 2 and that the bits need not arrive coherently.
module tsc_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tsc_cmd_rx.sv
// Command receiver: hunts for the start bit, gathers the control byte,
// opens the acquisition window and strobes the decoded fields.
// Assumes rise/fall are single-cycle pulses and clr is high while deselected.
module tsc_cmd_rx
    import tsc_pkg::*;
#(
    parameter int OPEN_HI = 16,
    parameter int OPEN_LO = 17,
    parameter int CNT_W   = 5
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     rise,
    input  logic     fall,
    input  logic     din,
    output logic     done,
    output logic     acq,
    output logic     cfg_vld,
    output tsc_cmd_t cfg
);
    localparam int               BC_W    = $clog2(CTRL_BITS);
    localparam logic [BC_W-1:0]  BC_LAST = BC_W'(CTRL_BITS - 1);
    localparam logic [BC_W-1:0]  BC_A0   = BC_W'(CH_W);
    localparam logic [CNT_W-1:0] LIM_HI  = CNT_W'(OPEN_HI - 1);
    localparam logic [CNT_W-1:0] LIM_LO  = CNT_W'(OPEN_LO - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic                   cap_on;
    logic [BC_W-1:0]        bit_cnt;
    logic [CTRL_BITS-2:0]   shreg;
    logic [CNT_W-1:0]       xfer_cnt;
    logic                   seen;
    logic                   mode8_cur;
    logic                   hunt_ok;
    logic                   start_hit;
    logic                   byte_last;
    tsc_cmd_t               cmd_nx;

    assign hunt_ok   = !cap_on && (!seen || xfer_cnt >= (mode8_cur ? LIM_LO : LIM_HI));
    assign start_hit = rise && hunt_ok && din;
    assign byte_last = cap_on && (bit_cnt == BC_LAST);
    assign cmd_nx    = tsc_cmd_t'({shreg[CTRL_BITS-3:0], din});

    // Capture the field bits after a start bit and track the active resolution
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cap_on    <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            seen      <= 1'b0;
            mode8_cur <= 1'b0;
        end else if (rise) begin
            if (cap_on) begin
                shreg   <= {shreg[CTRL_BITS-3:0], din};
                bit_cnt <= bit_cnt + 1'b1;
                if (byte_last) begin
                    cap_on    <= 1'b0;
                    mode8_cur <= cmd_nx.mode8;
                end
            end else if (hunt_ok && din) begin
                cap_on  <= 1'b1;
                bit_cnt <= BC_W'(1);
                seen    <= 1'b1;
            end
        end
    end

    // Count rising edges since the last start bit, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                     xfer_cnt <= '0;
        else if (start_hit)                    xfer_cnt <= CNT_W'(1);
        else if (rise && xfer_cnt != CNT_MAX)  xfer_cnt <= xfer_cnt + 1'b1;
    end

    // Publish the decoded fields and hand the conversion to the transmitter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            cfg_vld <= 1'b0;
            cfg     <= '0;
        end else begin
            done    <= 1'b0;
            cfg_vld <= 1'b0;
            if (!clr && rise && byte_last) begin
                done    <= 1'b1;
                cfg_vld <= 1'b1;
                cfg     <= cmd_nx;
            end
        end
    end

    // Hold the acquisition window from the channel LSB to the end of the byte
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                             acq <= 1'b0;
        else if (rise && cap_on && bit_cnt == BC_A0)   acq <= 1'b1;
        else if (fall && !cap_on)                      acq <= 1'b0;
    end
endmodule

// File: rtl/tsc_res_tx.sv
// Result transmitter: raises BUSY for one serial clock, then shifts the
// latched sample MSB first and fills with zeros afterwards.
// Assumes load and fall never coincide (they come from opposite edges).
module tsc_res_tx #(
    parameter int RES_HI = 12,
    parameter int RES_LO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fall,
    input  logic              load,
    input  logic              mode8,
    input  logic [RES_HI-1:0] sample,
    output logic              dout,
    output logic              busy
);
    localparam int                LEFT_W  = $clog2(RES_HI + 1);
    localparam logic [RES_HI-1:0] LO_KEEP = {{RES_LO{1'b1}}, {(RES_HI-RES_LO){1'b0}}};

    logic              arm;
    logic              arm_m8;
    logic [RES_HI-1:0] shreg;
    logic [LEFT_W-1:0] left;

    // Arm on a finished command, then drive BUSY and result bits on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            arm    <= 1'b0;
            arm_m8 <= 1'b0;
            shreg  <= '0;
            left   <= '0;
            dout   <= 1'b0;
            busy   <= 1'b0;
        end else begin
            if (load) begin
                arm    <= 1'b1;
                arm_m8 <= mode8;
            end
            if (fall) begin
                if (arm) begin
                    arm   <= 1'b0;
                    busy  <= 1'b1;
                    dout  <= 1'b0;
                    shreg <= arm_m8 ? (sample & LO_KEEP) : sample;
                    left  <= arm_m8 ? LEFT_W'(RES_LO) : LEFT_W'(RES_HI);
                end else if (left != '0) begin
                    busy  <= 1'b0;
                    dout  <= shreg[RES_HI-1];
                    shreg <= {shreg[RES_HI-2:0], 1'b0};
                    left  <= left - 1'b1;
                end else begin
                    busy  <= 1'b0;
                    dout  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/tsc_serial_if.sv
// Top of the touch ADC serial interface: synchronizes the host lines,
// finds serial clock edges and joins the command receiver and result
// transmitter. Assumes clk runs several times faster than dclk.
module tsc_serial_if
    import tsc_pkg::*;
#(
    parameter int RES_HI      = 12,
    parameter int RES_LO      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              dclk,
    input  logic              din,
    input  logic [RES_HI-1:0] sample,
    output logic              dout,
    output logic              busy,
    output logic              drv_en,
    output logic              acq,
    output logic              cfg_vld,
    output logic [CH_W-1:0]   cfg_chan,
    output logic              cfg_mode8,
    output logic              cfg_ref_ext,
    output logic [1:0]        cfg_pd
);
    localparam int OPEN_HI  = 2 * CTRL_BITS;
    localparam int OPEN_LO  = CTRL_BITS + 1 + RES_LO;
    localparam int OPEN_MAX = (OPEN_HI > OPEN_LO) ? OPEN_HI : OPEN_LO;
    localparam int CNT_W    = $clog2(OPEN_MAX + 1);

    logic     cs_s, dclk_s, din_s;
    logic     dclk_d;
    logic     dclk_rise, dclk_fall;
    logic     done;
    tsc_cmd_t cfg_q;

    tsc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, dclk, din}),
        .q     ({cs_s, dclk_s, din_s})
    );

    // Remember the previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) dclk_d <= 1'b0;
        else        dclk_d <= dclk_s;
    end

    // Track selection for the pad drive enable
    always_ff @(posedge clk) begin
        if (!rst_n) drv_en <= 1'b0;
        else        drv_en <= !cs_s;
    end

    assign dclk_rise = dclk_s & ~dclk_d;
    assign dclk_fall = ~dclk_s & dclk_d;

    tsc_cmd_rx #(.OPEN_HI(OPEN_HI), .OPEN_LO(OPEN_LO), .CNT_W(CNT_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cs_s),
        .rise    (dclk_rise),
        .fall    (dclk_fall),
        .din     (din_s),
        .done    (done),
        .acq     (acq),
        .cfg_vld (cfg_vld),
        .cfg     (cfg_q)
    );

    tsc_res_tx #(.RES_HI(RES_HI), .RES_LO(RES_LO)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cs_s),
        .fall   (dclk_fall),
        .load   (done),
        .mode8  (cfg_q.mode8),
        .sample (sample),
        .dout   (dout),
        .busy   (busy)
    );

    assign cfg_chan    = cfg_q.chan;
    assign cfg_mode8   = cfg_q.mode8;
    assign cfg_ref_ext = cfg_q.ref_ext;
    assign cfg_pd      = cfg_q.pd;
endmodule

// File: rtl/tsc_serial_if_chk.sv
// Property checker for the touch ADC serial interface, bound to the top.
module tsc_serial_if_chk (
    input logic clk,
    input logic rst_n,
    input logic drv_en,
    input logic dclk_rise,
    input logic dclk_fall,
    input logic dout,
    input logic busy,
    input logic acq,
    input logic cfg_vld
);
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> (!dout && !busy && !acq));

    // R11
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && !dclk_fall) |=> (!drv_en || $stable(dout)));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && !dclk_fall) |=> (!drv_en || $stable(busy)));

    // R3
    busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dclk_fall) |=> !busy);

    // R3
    busy_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(dclk_fall));

    // R8
    acq_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq) |-> $past(dclk_rise));

    // R8
    acq_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acq) |-> (busy || !drv_en));

    // R2
    cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_vld |=> !cfg_vld);
endmodule

bind tsc_serial_if tsc_serial_if_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_en    (drv_en),
    .dclk_rise (dclk_rise),
    .dclk_fall (dclk_fall),
    .dout      (dout),
    .busy      (busy),
    .acq       (acq),
    .cfg_vld   (cfg_vld)
);

// File: tb/tsc_serial_if_test.sv
// Directed bench for the touch ADC serial interface.
module tsc_serial_if_test;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        dclk = 1'b0;
    logic        din = 1'b0;
    logic [11:0] sample = '0;
    logic        dout, busy, drv_en, acq, cfg_vld, cfg_mode8, cfg_ref_ext;
    logic [2:0]  cfg_chan;
    logic [1:0]  cfg_pd;

    int checks = 0;
    int fails  = 0;
    int strobes = 0;
    logic [2:0] lf_chan;
    logic       lf_m8, lf_ref;
    logic [1:0] lf_pd;
    logic s_dout, s_busy, s_acq, m_dout, m_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsc_serial_if uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .din(din),
        .sample(sample), .dout(dout), .busy(busy), .drv_en(drv_en), .acq(acq),
        .cfg_vld(cfg_vld), .cfg_chan(cfg_chan), .cfg_mode8(cfg_mode8),
        .cfg_ref_ext(cfg_ref_ext), .cfg_pd(cfg_pd)
    );

    // Record field strobes away from the active edge
    always @(negedge clk) begin
        if (cfg_vld) begin
            strobes = strobes + 1;
            lf_chan = cfg_chan;
            lf_m8   = cfg_mode8;
            lf_ref  = cfg_ref_ext;
            lf_pd   = cfg_pd;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One serial clock: data set, rise, mid sample, fall, late sample
    task automatic tick(input logic d);
        din = d;
        repeat (H) @(negedge clk);
        dclk = 1'b1;
        repeat (H) @(negedge clk);
        m_dout = dout;
        m_busy = busy;
        dclk = 1'b0;
        repeat (H) @(negedge clk);
        s_dout = dout;
        s_busy = busy;
        s_acq  = acq;
    endtask

    function automatic logic exp_bit(input int t, input int bt, input int n, input logic [11:0] v);
        int j;
        j = t - bt - 1;
        if (j >= 0 && j < n) return v[n-1-j];
        return 1'b0;
    endfunction

    // Generic transfer scenario with optional second byte and a stray high bit
    task automatic run_seq(input int lead, input logic [7:0] b0, input logic [11:0] s0,
                           input int t2, input logic [7:0] b1, input logic [11:0] s1,
                           input bit acc, input int poke, input int ntick,
                           input string tag_a, input string tag_b, input string tag_s,
                           input int exp_str);
        int base, na, nb;
        logic [11:0] va, vb;
        logic d, eb, ea, ed, prev_busy, in_b;
        string tg;
        base = strobes;
        na = b0[3] ? 8 : 12;
        nb = b1[3] ? 8 : 12;
        va = b0[3] ? {4'h0, s0[11:4]} : s0;
        vb = b1[3] ? {4'h0, s1[11:4]} : s1;
        sample = s0;
        cs_n = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 0; i < lead; i++) begin
            tick(1'b0);
            chk("R1", "busy during leading zeros", s_busy, 0);
            chk("R1", "acq during leading zeros", s_acq, 0);
        end
        prev_busy = 1'b0;
        for (int t = 1; t <= ntick; t++) begin
            if (t <= 8) d = b0[8-t];
            else if (t2 != 0 && t >= t2 && t < t2 + 8) d = b1[7-(t-t2)];
            else d = (t == poke);
            tick(d);
            if (t == 8) sample = s1;
            in_b = acc && t2 != 0 && t > t2 + 7;
            eb = (t == 8) || (acc && t2 != 0 && t == t2 + 7);
            ea = (t >= 4 && t <= 7) || (acc && t2 != 0 && t >= t2 + 3 && t <= t2 + 6);
            ed = in_b ? exp_bit(t, t2 + 7, nb, vb) : exp_bit(t, 8, na, va);
            if (in_b && t <= t2 + 7 + nb) tg = tag_b;
            else if (!in_b && t > 8 && t <= 8 + na) tg = tag_a;
            else tg = "R6";
            chk("R3", $sformatf("busy after clock %0d", t), s_busy, eb);
            chk("R8", $sformatf("acq after clock %0d", t), s_acq, ea);
            chk(tg, $sformatf("dout after clock %0d", t), s_dout, ed);
            chk("R11", $sformatf("busy before fall %0d", t), m_busy, prev_busy);
            prev_busy = eb;
        end
        chk(tag_s, "field strobe count", strobes - base, exp_str);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R7", "drv_en after deselect", drv_en, 0);
    endtask

    task automatic test_reset;
        chk("R7", "drv_en in reset state", drv_en, 0);
        chk("R7", "dout in reset state", dout, 0);
        chk("R7", "busy in reset state", busy, 0);
        chk("R7", "acq in reset state", acq, 0);
        chk("R2", "strobe in reset state", cfg_vld, 0);
    endtask

    task automatic test_basic12;
        run_seq(3, 8'hD6, 12'hA5C, 0, 8'h00, 12'h000, 0, 0, 24, "R4", "R4", "R1", 1);
        chk("R2", "channel field", lf_chan, 5);
        chk("R2", "resolution field", lf_m8, 0);
        chk("R2", "reference field", lf_ref, 1);
        chk("R2", "power field", lf_pd, 2);
    endtask

    task automatic test_basic8;
        run_seq(0, 8'hB9, 12'h3C7, 0, 8'h00, 12'h000, 0, 0, 24, "R5", "R5", "R2", 1);
        chk("R2", "channel field", lf_chan, 3);
        chk("R2", "resolution field", lf_m8, 1);
        chk("R2", "reference field", lf_ref, 0);
        chk("R2", "power field", lf_pd, 1);
    endtask

    task automatic test_overlap16;
        run_seq(0, 8'h96, 12'h5A3, 17, 8'hD2, 12'hC31, 1, 0, 37, "R4", "R9", "R9", 2);
        chk("R2", "second channel field", lf_chan, 5);
        chk("R2", "second reference field", lf_ref, 0);
    endtask

    task automatic test_overlap15;
        run_seq(0, 8'h96, 12'h6E9, 16, 8'hF5, 12'h2B4, 1, 0, 36, "R4", "R9", "R9", 2);
        chk("R2", "second channel field", lf_chan, 7);
    endtask

    task automatic test_early12;
        run_seq(0, 8'hD6, 12'h9F0, 0, 8'h00, 12'h000, 0, 15, 26, "R4", "R4", "R9", 1);
    endtask

    task automatic test_early8;
        run_seq(0, 8'hB9, 12'hE17, 16, 8'h80, 12'h000, 0, 0, 26, "R5", "R5", "R10", 1);
    endtask

    task automatic test_accept8;
        run_seq(0, 8'hB9, 12'h4D2, 17, 8'hAD, 12'h8B6, 1, 0, 33, "R5", "R10", "R10", 2);
    endtask

    task automatic test_abort;
        cs_n = 1'b0;
        repeat (10) @(negedge clk);
        for (int t = 1; t <= 8; t++) tick(8'hD6 >> (8 - t));
        chk("R3", "busy before abort", s_busy, 1);
        cs_n = 1'b1;
        repeat (H) @(negedge clk);
        chk("R7", "drv_en after abort", drv_en, 0);
        chk("R7", "busy after abort", busy, 0);
        chk("R7", "dout after abort", dout, 0);
        repeat (4) @(negedge clk);
        run_seq(0, 8'hB9, 12'h3C7, 0, 8'h00, 12'h000, 0, 0, 20, "R5", "R5", "R7", 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        test_reset;
        test_basic12;
        test_basic8;
        test_overlap16;
        test_overlap15;
        test_early12;
        test_early8;
        test_accept8;
        test_abort;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule